// File: doc/BRIEF.md
# Serial Port Interrupt Identification and Status Logic

This block is the interrupt and status core of a byte-wide legacy serial port register file. It combines four interrupt sources into one level interrupt line and a fixed-priority identification code. The sources are a latched receive overrun, the presence of buffered receive data, a pending transmit-empty notice and an external modem-change flag. It also makes the reads that have side effects behave as software expects. A read of the identification register retires a transmit-empty notice, and a read of line status retires the overrun.

A thin register wrapper sits around that core. It provides the eight-offset byte bus decode, a small receive buffer that the receiver fills through a valid/ready stream, a divisor latch that is reached through a bank-select bit, a scratch byte and the transmit byte output. The transmitter is modelled as always ready, so each accepted data write leaves on `tx_valid` one cycle later, and that output has no back-pressure. On the receive stream a byte is taken on any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` drops while the buffer is full and during any write to the buffer-control offset. A byte offered while `rx_ready` is low is not taken, and the sender must hold it.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The reported reason follows a fixed priority, highest first: overrun (enable bit 2), receive data buffered (enable bit 0), transmit-empty pending (enable bit 1), modem change (enable bit 3).
- R2: Reading offset 2 returns the reason code in bits 3:0: 0x6 overrun, 0xC receive data, 0x2 transmit empty, 0x0 modem change, 0x1 nothing pending. Bits 7:6 read 11 while the buffer enable (bit 0 of the last offset-2 write) is set, and read 00 otherwise.
- R3: A write to offset 1 with bank select clear stores only bits 3:0 of the enable register. Reads return bits 7:4 as zero.
- R4: A data write (offset 0, bank select clear) sets the transmit-empty pending flag and presents the byte on `tx_data` with `tx_valid` high for exactly the next cycle. An offset-2 read whose reported reason is transmit empty clears the flag.
- R5: Reading offset 5 returns bit 6 and bit 5 set, bit 1 equal to the overrun flag and bit 0 set exactly when the receive buffer holds data, with the other bits zero. The read clears the overrun flag unless `ovr_evt` is high in the same cycle. A pulse on `ovr_evt` sets the flag.
- R6: `irq` is high exactly when some reason is active. It reflects every register access and every received byte from the cycle after the edge that applies it.
- R7: While bit 7 of the line control byte (offset 3, read/write) is set, offsets 0 and 1 read and write the divisor low and high bytes. The divisor resets to 12.
- R8: Reads of offsets 4 and 6, and data reads of an empty buffer, return 0xFF. Writes to offset 5 change nothing.
- R9: The receive buffer holds 1 byte while disabled and DEPTH bytes while enabled, and `rx_ready` is low when it is full. A change of the enable bit empties it, and so does a write with both bit 0 and bit 1 set. A data read removes the oldest byte.
- R10: Offset 7 is a scratch byte that reads back the last value written to it.
- R11: After reset the enable register, line control and scratch bytes read 0, offset 2 reads 0x01 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the access cycle |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive buffer can accept |
| rx_data | input | 8 | Receive byte |
| ovr_evt | input | 1 | Receiver overrun event pulse |
| modem_delta | input | 1 | Modem status change flag (level) |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| divisor | output | 16 | Baud divisor |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives every offset and the receive stream against a behavioural model. It targets the cases where several sources are active at once. A wrong priority would show the lower reason in the identification read. The bench also checks that an identification read retires the transmit-empty notice only when that notice is the one reported. A design that cleared it while a higher reason was shown would lose the transmit interrupt. It fills the buffer to its edge in both capacities and confirms that a full buffer refuses bytes. It toggles the enable to confirm the buffer is emptied, and a design that kept stale bytes would return them on later data reads. The bench also checks that an overrun arriving in the same cycle as a line-status read survives that read, and that the bank-select bit steers offsets 0 and 1 away from the buffer and the enable register.

// File: rtl/uart_ic_pkg.sv
package uart_ic_pkg;
  typedef enum logic [3:0] {
    IID_MODEM = 4'h0,
    IID_NONE  = 4'h1,
    IID_TXE   = 4'h2,
    IID_LINE  = 4'h6,
    IID_RXD   = 4'hC
  } iid_e;

  localparam logic [2:0] OFS_DATA  = 3'd0;
  localparam logic [2:0] OFS_IEN   = 3'd1;
  localparam logic [2:0] OFS_IDENT = 3'd2;
  localparam logic [2:0] OFS_LCTL  = 3'd3;
  localparam logic [2:0] OFS_LSTAT = 3'd5;
  localparam logic [2:0] OFS_SCR   = 3'd7;

  localparam int IEN_RX    = 0;
  localparam int IEN_TX    = 1;
  localparam int IEN_LINE  = 2;
  localparam int IEN_MODEM = 3;
  localparam int LCTL_BANK = 7;
endpackage

// File: rtl/uart_ic_rxbuf.sv
module uart_ic_rxbuf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wide,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          has_room
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] limit;

  assign limit    = wide ? CW'(DEPTH) : CW'(1);
  assign has_room = count < limit;
  assign head     = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count < limit);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != 0);
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uart_ic_prio.sv
module uart_ic_prio
  import uart_ic_pkg::*;
(
  input  logic [3:0] ien,
  input  logic       ovr,
  input  logic       rx_avail,
  input  logic       tx_pend,
  input  logic       modem_chg,
  output iid_e       iid
);
  always_comb begin
    if (ovr && ien[IEN_LINE])            iid = IID_LINE;
    else if (rx_avail && ien[IEN_RX])    iid = IID_RXD;
    else if (tx_pend && ien[IEN_TX])     iid = IID_TXE;
    else if (modem_chg && ien[IEN_MODEM]) iid = IID_MODEM;
    else                                 iid = IID_NONE;
  end
endmodule

// File: rtl/uart_ic_divlatch.sv
module uart_ic_divlatch #(
  parameter int DW          = 16,
  parameter int RESET_DIV   = 12,
  localparam int HW         = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [HW-1:0] wdata,
  output logic [DW-1:0] divisor
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divisor <= DW'(RESET_DIV);
    else begin
      if (wr_lo) divisor[HW-1:0]  <= wdata;
      if (wr_hi) divisor[DW-1:HW] <= wdata;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_ic_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RESET_DIV = 12,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        ovr_evt,
  input  logic        modem_delta,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic [15:0] divisor,
  output logic        irq
);
  logic [3:0]    ier_q;
  logic [7:0]    lctl_q, scr_q;
  logic          buf_en_q, txe_q, ovr_q;
  logic          bank, acc_rd, acc_wr;
  logic          wr_data, wr_lo, wr_hi, wr_ien, wr_bctl;
  logic          rd_data, rd_ident, rd_lstat;
  logic          flush, push, pop, has_room;
  logic [7:0]    head;
  logic [CW-1:0] count;
  logic          rx_avail;
  iid_e          iid;
  logic [7:0]    ident_val, lstat_val;

  assign bank     = lctl_q[LCTL_BANK];
  assign acc_rd   = bus_sel && !bus_wr;
  assign acc_wr   = bus_sel && bus_wr;
  assign wr_data  = acc_wr && bus_addr == OFS_DATA && !bank;
  assign wr_lo    = acc_wr && bus_addr == OFS_DATA && bank;
  assign wr_ien   = acc_wr && bus_addr == OFS_IEN && !bank;
  assign wr_hi    = acc_wr && bus_addr == OFS_IEN && bank;
  assign wr_bctl  = acc_wr && bus_addr == OFS_IDENT;
  assign rd_data  = acc_rd && bus_addr == OFS_DATA && !bank;
  assign rd_ident = acc_rd && bus_addr == OFS_IDENT;
  assign rd_lstat = acc_rd && bus_addr == OFS_LSTAT;

  assign flush    = wr_bctl && ((bus_wdata[0] != buf_en_q) || (bus_wdata[0] && bus_wdata[1]));
  assign rx_avail = count != '0;
  assign rx_ready = has_room && !wr_bctl;
  assign push     = rx_valid && rx_ready;
  assign pop      = rd_data && rx_avail;

  uart_ic_rxbuf #(.DEPTH(DEPTH), .W(8)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wide(buf_en_q),
    .push(push), .push_data(rx_data), .pop(pop),
    .head(head), .count(count), .has_room(has_room)
  );

  uart_ic_prio u_prio (
    .ien(ier_q), .ovr(ovr_q), .rx_avail(rx_avail), .tx_pend(txe_q),
    .modem_chg(modem_delta), .iid(iid)
  );

  uart_ic_divlatch #(.DW(16), .RESET_DIV(RESET_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .divisor(divisor)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q    <= '0;
      lctl_q   <= '0;
      scr_q    <= '0;
      buf_en_q <= 1'b0;
      txe_q    <= 1'b0;
      ovr_q    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr_data;
      if (wr_data) tx_data <= bus_wdata;
      if (wr_ien) ier_q <= bus_wdata[3:0];
      if (wr_bctl) buf_en_q <= bus_wdata[0];
      if (acc_wr && bus_addr == OFS_LCTL) lctl_q <= bus_wdata;
      if (acc_wr && bus_addr == OFS_SCR)  scr_q  <= bus_wdata;
      if (wr_data) txe_q <= 1'b1;
      else if (rd_ident && iid == IID_TXE) txe_q <= 1'b0;
      if (ovr_evt) ovr_q <= 1'b1;
      else if (rd_lstat) ovr_q <= 1'b0;
    end
  end

  assign ident_val = {buf_en_q, buf_en_q, 2'b00, iid};
  assign lstat_val = {1'b0, 1'b1, 1'b1, 3'b000, ovr_q, rx_avail};
  assign irq       = iid != IID_NONE;

  always_comb begin
    bus_rdata = 8'hFF;
    unique case (bus_addr)
      OFS_DATA:  bus_rdata = bank ? divisor[7:0] : (rx_avail ? head : 8'hFF);
      OFS_IEN:   bus_rdata = bank ? divisor[15:8] : {4'b0000, ier_q};
      OFS_IDENT: bus_rdata = ident_val;
      OFS_LCTL:  bus_rdata = lctl_q;
      OFS_LSTAT: bus_rdata = lstat_val;
      OFS_SCR:   bus_rdata = scr_q;
      default:   bus_rdata = 8'hFF;
    endcase
  end

  assert_line_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && ier_q[IEN_LINE]) |-> iid == IID_LINE);
  assert_txe_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> txe_q && tx_valid);
  assert_txe_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && iid == IID_TXE) |=> !txe_q);
  assert_ovr_retire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lstat && !ovr_evt) |=> !ovr_q);
  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ier_q != 4'h0);
  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rx_avail);
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_data = '0;
  logic rx_valid = 0, ovr_evt = 0, modem_delta = 0;
  logic [7:0] bus_rdata, tx_data;
  logic rx_ready, tx_valid, irq;
  logic [15:0] divisor;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int q[$];
  logic [3:0] m_ier;
  logic [7:0] m_lctl, m_scr, m_dlo, m_dhi, m_txd;
  logic m_en, m_txe, m_ovr, m_txv;

  always #5 clk = ~clk;

  uart_irq_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ovr_evt(ovr_evt), .modem_delta(modem_delta), .tx_valid(tx_valid),
    .tx_data(tx_data), .divisor(divisor), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_reason();
    if (m_ovr && m_ier[2]) return 'h6;
    if (q.size() > 0 && m_ier[0]) return 'hC;
    if (m_txe && m_ier[1]) return 'h2;
    if (modem_delta && m_ier[3]) return 'h0;
    return 'h1;
  endfunction

  function automatic int m_cap();
    return m_en ? DEPTH : 1;
  endfunction

  function automatic bit m_ready();
    return (q.size() < m_cap()) && !(bus_sel && bus_wr && bus_addr == 3'd2);
  endfunction

  function automatic int m_rdata(output string tag);
    bit bk = m_lctl[7];
    tag = "R8";
    case (bus_addr)
      3'd0: begin
        if (bk) begin tag = "R7"; return m_dlo; end
        tag = (q.size() > 0) ? "R9" : "R8";
        return (q.size() > 0) ? q[0] : 'hFF;
      end
      3'd1: begin
        if (bk) begin tag = "R7"; return m_dhi; end
        tag = "R3"; return m_ier;
      end
      3'd2: begin tag = "R1,R2"; return m_reason() | (m_en ? 'hC0 : 0); end
      3'd3: begin tag = "R7"; return m_lctl; end
      3'd5: begin tag = "R5"; return 'h60 | (m_ovr << 1) | (q.size() > 0); end
      3'd7: begin tag = "R10"; return m_scr; end
      default: return 'hFF;
    endcase
  endfunction

  task automatic model_reset();
    q.delete();
    m_ier = 0; m_lctl = 0; m_scr = 0; m_dlo = 8'd12; m_dhi = 0;
    m_en = 0; m_txe = 0; m_ovr = 0; m_txv = 0; m_txd = 0;
  endtask

  // one clock: drive, compare before edge, advance model at edge
  task automatic cyc(input bit s, input bit w, input logic [2:0] a, input logic [7:0] d,
                     input bit rv, input logic [7:0] rdat, input bit oe, input bit md);
    int rsn; bit rdy, bk; string tag; int er;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rdat; ovr_evt = oe; modem_delta = md;
    #1;
    rsn = m_reason(); rdy = m_ready(); bk = m_lctl[7];
    chk(irq == (rsn != 1), "R6 irq", irq, rsn != 1);
    chk(rx_ready == rdy, "R9 rx_ready", rx_ready, rdy);
    chk(tx_valid == m_txv, "R4 tx_valid", tx_valid, m_txv);
    if (m_txv) chk(tx_data == m_txd, "R4 tx_data", tx_data, m_txd);
    chk(divisor == {m_dhi, m_dlo}, "R7 divisor", divisor, {m_dhi, m_dlo});
    if (s && !w) begin
      er = m_rdata(tag);
      chk(bus_rdata == er[7:0], tag, bus_rdata, er);
    end
    @(posedge clk);
    m_txv = 0;
    if (s && w) begin
      case (a)
        3'd0: if (bk) m_dlo = d; else begin m_txe = 1; m_txv = 1; m_txd = d; end
        3'd1: if (bk) m_dhi = d; else m_ier = d[3:0];
        3'd2: begin
          if (d[0] != m_en || (d[0] && d[1])) q.delete();
          m_en = d[0];
        end
        3'd3: m_lctl = d;
        3'd7: m_scr = d;
        default: ;
      endcase
    end
    if (s && !w) begin
      if (a == 3'd0 && !bk && q.size() > 0) void'(q.pop_front());
      if (a == 3'd2 && rsn == 2) m_txe = 0;
      if (a == 3'd5) m_ovr = 0;
    end
    if (rv && rdy) q.push_back(rdat);
    if (oe) m_ovr = 1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1, 1, a, d, 0, 0, 0, modem_delta);
  endtask
  task automatic rd(input logic [2:0] a);
    cyc(1, 0, a, 0, 0, 0, 0, modem_delta);
  endtask
  task automatic rx(input logic [7:0] b);
    cyc(0, 0, 0, 0, 1, b, 0, modem_delta);
  endtask
  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, modem_delta);
  endtask

  bit finished = 0;

  initial begin
    #2_000_000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    idle();
    chk(irq == 0, "R11 irq after reset", irq, 0);
    rd(3'd2); rd(3'd1); rd(3'd3); rd(3'd7); rd(3'd5); rd(3'd0);
    // R8 undefined offsets
    rd(3'd4); rd(3'd6);
    // R10 scratch
    wr(3'd7, 8'hA5); rd(3'd7); wr(3'd7, 8'h3C); rd(3'd7);
    // R7 divisor bank
    wr(3'd3, 8'h83); rd(3'd0); rd(3'd1);
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); rd(3'd0); rd(3'd1);
    chk(tx_valid == 0, "R7 bank write not sent", tx_valid, 0);
    wr(3'd3, 8'h03); rd(3'd1); rd(3'd3);
    // R3 enable mask
    wr(3'd1, 8'hFF); rd(3'd1); wr(3'd1, 8'h00);
    // R4 transmit-empty re-arm and retire
    wr(3'd0, 8'h55); idle();
    wr(3'd1, 8'h02); rd(3'd2); rd(3'd2);
    wr(3'd0, 8'h66); wr(3'd0, 8'h77); rd(3'd2); idle();
    // R9 single-byte buffer, R1 rx over tx
    wr(3'd0, 8'h11); wr(3'd1, 8'h03);
    rx(8'hC1); rx(8'hC2); rx(8'hC3);
    rd(3'd2); rd(3'd5); rd(3'd0); rd(3'd0); rd(3'd2); rd(3'd2);
    // R1 full stack of reasons, R5 overrun
    wr(3'd1, 8'h0F); wr(3'd0, 8'h22);
    cyc(0, 0, 0, 0, 1, 8'h9A, 1, 1);
    rd(3'd2); rd(3'd5); rd(3'd2); rd(3'd0); rd(3'd2); rd(3'd2); rd(3'd2);
    cyc(1, 0, 3'd5, 0, 0, 0, 1, 1); rd(3'd5); rd(3'd5);
    // R8 write to line status ignored
    cyc(0, 0, 0, 0, 0, 0, 1, 0); wr(3'd5, 8'h00); rd(3'd5); rd(3'd5);
    // R9 wide buffer fill, flush and disable
    wr(3'd2, 8'h01); rd(3'd2);
    for (int i = 0; i < DEPTH + 2; i++) rx(8'(i + 8'h40));
    rd(3'd0); rd(3'd0); rd(3'd5);
    cyc(1, 1, 3'd2, 8'h03, 1, 8'hEE, 0, 0);
    rd(3'd0); rx(8'h5A); rx(8'h5B);
    wr(3'd2, 8'h00); rd(3'd0); rd(3'd2); rx(8'h61); rd(3'd0);
    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a = 3'($urandom_range(0, 7));
      logic [7:0] d = 8'($urandom);
      bit s = ($urandom_range(0, 2) != 0);
      bit w = $urandom_range(0, 1) == 1;
      if (w && a == 3'd3) d[7] = ($urandom_range(0, 5) == 0);
      cyc(s, w, a, d, $urandom_range(0, 1) == 1, 8'($urandom),
          $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule